// File: doc/BRIEF.md
# Linear-Interpolation Synchronous Resampler

This block turns a stream of samples taken at a free-running, slightly wrong rate into samples placed on a fixed frame grid. Samples are written one at a time into a circular store. At each frame tick, a control word gives two values: how many samples arrived during that frame and the tick-counter value latched at the tick. The frame spans a whole frame period. A frame of `N` samples therefore has an actual sample period of (tick delta)/N. The grid spacing is (tick delta)/`OUT_N`. Their ratio, which is the step between grid points measured in buffer positions, reduces exactly to N/`OUT_N`, so no divider is needed. The step is kept as a fixed-point value with 16 fraction bits.

Each accepted frame produces a block of `BLK_N` outputs centred on the frame tick. The tick position in the buffer, called the anchor, is the running sum of all sample counts since reset. Grid point `i` lies at `anchor - (BLK_N/2)*step + i*step`. The integer part `m` of that position and its 16-bit fraction `d` select and weight the two neighbouring stored samples. The blend is rounded to the input sample width. Jobs wait in a short queue. A two-state machine works through them: `S_IDLE` pops a queued job and moves to `S_RUN`. `S_RUN` emits one output per cycle while sample `m+1` is present and holds otherwise. After the last point of the block it returns to `S_IDLE`.

Top module: `sync_resampler`

## Requirements
- R1: After reset, `out_valid` and `out_last` are low, and they stay low until a block is emitted.
- R2: The first control word after reset only records its tick value and emits no block. Its sample count still adds to the anchor.
- R3: A control word whose tick equals the previous tick emits no block. Its sample count still adds to the anchor.
- R4: For an accepted frame with count N, the step is N·2^16/`OUT_N` in units of 2^-16 sample. Output `i` (0..`BLK_N`-1) uses position `anchor·2^16 - (BLK_N/2)·step + i·step`. Here `m` is the position shifted right by 16 and `d` is its low 16 bits.
- R5: Each output equals floor((s(m)·(2^16-d) + s(m+1)·d + 2^15) / 2^16), using signed samples.
- R6: A frame whose first position would fall below zero emits no block.
- R7: No output uses sample `m+1` before that sample has been written. Emission stalls while the sample is missing and resumes once it is written.
- R8: Blocks come out whole and in frame order. `out_last` is high only on the `BLK_N`-th output of each block.
- R9: Sample `n` is stored at address n modulo `DEPTH`, and reads wrap the same way. Results stay correct after more than `DEPTH` samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Write one input sample this cycle |
| smp_data | input | DATA_W | Signed input sample |
| ci_valid | input | 1 | Frame control word present |
| ci_count | input | NCNT_W | Samples acquired in the frame just ended |
| ci_tick | input | TICK_W | Tick counter latched at the frame tick |
| out_valid | output | 1 | Resampled value present |
| out_data | output | DATA_W | Signed resampled value |
| out_last | output | 1 | Final value of the current block |

## Verification
Once sample `m+1` is present, an output is registered on the next rising edge. So when the sample that releases a stall is written at edge E, `S_RUN` sees it during the following cycle and the value appears after edge E+1. The bench samples outputs at the falling edge and compares them in order against a queue of expected values. It computes that queue when each control word is issued, so the checks do not depend on exact cycle counts. Each output is also checked against the number of samples the bench had already written. This confirms that no value was produced before its right-hand neighbour existed.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int FRAC_W = 16;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } rs_state_t;
endpackage

// File: rtl/rs_sample_ring.sv
module rs_sample_ring #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr_a,
    input  logic [AW-1:0]     rd_addr_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data_a = mem[rd_addr_a];
    assign rd_data_b = mem[rd_addr_b];
endmodule

// File: rtl/rs_job_fifo.sv
module rs_job_fifo #(
    parameter int W     = 80,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   used;

    assign empty = (used == '0);
    assign full  = (used == (AW+1)'(DEPTH));
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
        end else begin
            if (push && !full) begin
                mem[wp] <= din;
                wp      <= wp + 1'b1;
            end
            if (pop && !empty) rp <= rp + 1'b1;
            used <= used + (AW+1)'(push && !full) - (AW+1)'(pop && !empty);
        end
    end

    // R8: jobs are only taken when one is queued, so blocks keep frame order
    a_r8_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rs_lerp.sv
module rs_lerp #(
    parameter int DATA_W = 16,
    parameter int FRAC_W = 16,
    localparam int ACC_W = DATA_W + FRAC_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              last_in,
    input  logic [DATA_W-1:0] s_lo,
    input  logic [DATA_W-1:0] s_hi,
    input  logic [FRAC_W-1:0] frac,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    localparam logic [FRAC_W:0] ONE = (FRAC_W+1)'(1) << FRAC_W;
    localparam logic signed [ACC_W-1:0] RND = ACC_W'(1) << (FRAC_W-1);

    logic [FRAC_W:0] w_lo;
    logic signed [ACC_W-1:0] a_lo, a_hi, k_lo, k_hi, acc;
    logic signed [DATA_W-1:0] min_s, max_s, min_q, max_q;

    always_comb begin
        w_lo = ONE - {1'b0, frac};
        a_lo = {{(ACC_W-DATA_W){s_lo[DATA_W-1]}}, s_lo};
        a_hi = {{(ACC_W-DATA_W){s_hi[DATA_W-1]}}, s_hi};
        k_lo = {{(ACC_W-FRAC_W-1){1'b0}}, w_lo};
        k_hi = {{(ACC_W-FRAC_W){1'b0}}, frac};
        acc  = a_lo * k_lo + a_hi * k_hi + RND;
        if ($signed(s_lo) < $signed(s_hi)) begin
            min_s = $signed(s_lo);
            max_s = $signed(s_hi);
        end else begin
            min_s = $signed(s_hi);
            max_s = $signed(s_lo);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
            min_q     <= '0;
            max_q     <= '0;
        end else begin
            out_valid <= en;
            out_last  <= en && last_in;
            if (en) begin
                out_data <= acc[FRAC_W+DATA_W-1:FRAC_W];
                min_q    <= min_s;
                max_q    <= max_s;
            end
        end
    end

    // R5: a weighted blend never leaves the span of its two samples
    a_r5_between: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($signed(out_data) >= min_q && $signed(out_data) <= max_q));
endmodule

// File: rtl/sync_resampler.sv
module sync_resampler #(
    parameter int DATA_W  = 16,
    parameter int TICK_W  = 32,
    parameter int NCNT_W  = 10,
    parameter int CNT_W   = 24,
    parameter int OUT_N   = 128,
    parameter int BLK_N   = 512,
    parameter int DEPTH   = 1024,
    parameter int QDEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              ci_valid,
    input  logic [NCNT_W-1:0] ci_count,
    input  logic [TICK_W-1:0] ci_tick,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    import rs_pkg::*;

    localparam int AW       = $clog2(DEPTH);
    localparam int OUT_LOG2 = $clog2(OUT_N);
    localparam int BLK_LOG2 = $clog2(BLK_N);
    localparam int STEP_SH  = FRAC_W - OUT_LOG2;
    localparam int HALF_SH  = BLK_LOG2 - 1;
    localparam int POS_W    = CNT_W + FRAC_W;
    localparam int JOB_W    = 2 * POS_W;

    // ---------------- sample write side ----------------
    logic [CNT_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) wcnt <= '0;
        else if (smp_valid) wcnt <= wcnt + 1'b1;
    end

    // ---------------- control-info intake ----------------
    logic [CNT_W-1:0]  anchor_acc, anchor_new;
    logic [TICK_W-1:0] prev_tick;
    logic              have_tick;
    logic [POS_W-1:0]  step_new, half_span, anchor_pos;
    logic              job_ok;

    always_comb begin
        anchor_new = anchor_acc + CNT_W'(ci_count);
        step_new   = POS_W'(ci_count) << STEP_SH;
        half_span  = step_new << HALF_SH;
        anchor_pos = {anchor_new, {FRAC_W{1'b0}}};
        job_ok     = ci_valid && have_tick && (ci_tick != prev_tick)
                     && (anchor_pos >= half_span);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            anchor_acc <= '0;
            prev_tick  <= '0;
            have_tick  <= 1'b0;
        end else if (ci_valid) begin
            anchor_acc <= anchor_new;
            prev_tick  <= ci_tick;
            have_tick  <= 1'b1;
        end
    end

    logic             q_pop, q_empty, q_full;
    logic [JOB_W-1:0] q_dout;

    rs_job_fifo #(.W(JOB_W), .DEPTH(QDEPTH)) u_jobs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (job_ok),
        .din   ({anchor_pos - half_span, step_new}),
        .pop   (q_pop),
        .dout  (q_dout),
        .empty (q_empty),
        .full  (q_full)
    );

    // ---------------- sequencing FSM ----------------
    rs_state_t state, state_nx;
    logic [POS_W-1:0]    pos, step;
    logic [BLK_LOG2-1:0] idx;
    logic [CNT_W-1:0]    m_int;
    logic                rd_go, blk_end;

    assign m_int   = pos[POS_W-1:FRAC_W];
    assign rd_go   = (state == S_RUN) && (({1'b0, m_int} + (CNT_W+1)'(2)) <= {1'b0, wcnt});
    assign blk_end = (idx == BLK_LOG2'(BLK_N - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        q_pop    = 1'b0;
        unique case (state)
            S_IDLE: if (!q_empty) begin
                q_pop    = 1'b1;
                state_nx = S_RUN;
            end
            S_RUN:  if (rd_go && blk_end) state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos  <= '0;
            step <= '0;
            idx  <= '0;
        end else if (q_pop) begin
            pos  <= q_dout[JOB_W-1:POS_W];
            step <= q_dout[POS_W-1:0];
            idx  <= '0;
        end else if (rd_go) begin
            pos  <= pos + step;
            idx  <= idx + 1'b1;
        end
    end

    // ---------------- storage and blend ----------------
    logic [DATA_W-1:0] s_lo, s_hi;
    logic [CNT_W-1:0]  m_nxt;

    assign m_nxt = m_int + 1'b1;

    rs_sample_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .wr_en     (smp_valid),
        .wr_addr   (wcnt[AW-1:0]),
        .wr_data   (smp_data),
        .rd_addr_a (m_int[AW-1:0]),
        .rd_addr_b (m_nxt[AW-1:0]),
        .rd_data_a (s_lo),
        .rd_data_b (s_hi)
    );

    rs_lerp #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_lerp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (rd_go),
        .last_in   (blk_end),
        .s_lo      (s_lo),
        .s_hi      (s_hi),
        .frac      (pos[FRAC_W-1:0]),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // ---------------- assertions ----------------
    logic [BLK_LOG2-1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n)        seen <= '0;
        else if (out_last) seen <= '0;
        else if (out_valid) seen <= seen + 1'b1;
    end

    // R8: the closing flag marks exactly the BLK_N-th value of a block
    a_r8_last_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (seen == BLK_LOG2'(BLK_N - 1)));

    a_r8_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R7: a stalled read position stays put until its sample arrives
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && !rd_go) |=> $stable(pos));

    // R1: nothing is emitted while no block is being worked
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && $past(state) == S_IDLE) |-> !out_valid);
endmodule

// File: tb/sync_resampler_tb.sv
`timescale 1ns/1ps
module sync_resampler_tb;
    localparam int DATA_W = 16;
    localparam int TICK_W = 32;
    localparam int NCNT_W = 10;
    localparam int OUT_N  = 128;
    localparam int BLK_N  = 512;
    localparam int DEPTH  = 1024;
    localparam int NFR    = 10;

    // frame table: sample count and tick delta (0 = repeated tick)
    localparam int FR_N  [NFR] = '{128, 130, 128, 126, 128, 132, 124, 128, 129, 127};
    localparam int FR_DT [NFR] = '{100, 3360000, 3360010, 3359990, 0,
                                   3360005, 3359995, 3360000, 3360002, 3359998};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              ci_valid = 1'b0;
    logic [NCNT_W-1:0] ci_count = '0;
    logic [TICK_W-1:0] ci_tick = '0;
    logic              out_valid, out_last;
    logic [DATA_W-1:0] out_data;

    always #2.5 clk = ~clk;

    sync_resampler u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .ci_valid(ci_valid), .ci_count(ci_count), .ci_tick(ci_tick),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    typedef struct { int val; bit last; longint m; } exp_t;
    exp_t   expq[$];
    int     checks = 0;
    int     errors = 0;
    longint written = 0;
    longint anchor = 0;
    longint tick = 0;
    int     outs = 0;
    int     wraps = 0;
    bit     done = 0;

    function automatic int smp(longint n);
        return int'((n * 97) % 1999) - 999;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_samples(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            smp_valid = 1'b1;
            smp_data  = DATA_W'(smp(written));
            written++;
        end
        @(posedge clk); #1;
        smp_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // model of R2 R3 R4 R5 R6 for one control word
    task automatic send_ci(int k, int n, int dt);
        longint step, base, pos, d, m, v;
        anchor += n;
        tick   += dt;
        step = longint'(n) << 9;
        base = (anchor << 16) - (step << 8);
        if (k > 0 && dt != 0 && base >= 0) begin
            for (int i = 0; i < BLK_N; i++) begin
                exp_t e;
                pos = base + i * step;
                m = pos >>> 16;
                d = pos & 65535;
                v = (longint'(smp(m)) * (65536 - d) + longint'(smp(m + 1)) * d + 32768) >>> 16;
                e.val = int'(v); e.last = (i == BLK_N - 1); e.m = m;
                expq.push_back(e);
            end
        end
        @(posedge clk); #1;
        ci_valid = 1'b1;
        ci_count = NCNT_W'(n);
        ci_tick  = TICK_W'(tick);
        @(posedge clk); #1;
        ci_valid = 1'b0;
    endtask

    // output monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                outs++;
                if (expq.size() == 0) begin
                    check(0, "R8 unexpected output", 1, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check($signed(out_data) == e.val, "R4 R5 value", $signed(out_data), e.val);
                    check(out_last == e.last, "R8 last flag", out_last, e.last);
                    check(e.m + 1 < written, "R7 neighbour written", written, e.m + 2);
                    if (e.m >= DEPTH) wraps++;
                end
            end else begin
                if (out_last) check(0, "R8 last without valid", 1, 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", expq.size());
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        #0.5;
        check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        check(out_last == 1'b0, "R1 reset last", out_last, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(3);
        check(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);

        tick = 1000;
        for (int k = 0; k < NFR; k++) begin
            write_samples(FR_N[k]);
            send_ci(k, FR_N[k], FR_DT[k]);
            idle(420);
        end

        // R7: with input held back, the latest blocks must stay pending
        idle(600);
        check(expq.size() > 0, "R7 stall pending", expq.size(), 1);
        if (expq.size() > 0)
            check(expq[0].m + 1 >= written, "R7 stalled on missing sample", expq[0].m + 1, written);

        write_samples(300);
        for (int i = 0; i < 3000 && expq.size() > 0; i++) idle(1);
        idle(5);
        check(expq.size() == 0, "R7 stall released", expq.size(), 0);
        // R2 R3 R6: frames 0, 1 and 4 are dropped, seven blocks remain
        check(outs == 7 * BLK_N, "R2 R3 R6 block count", outs, 7 * BLK_N);
        check(wraps > 0, "R9 wrapped reads", wraps, 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule